// File: doc/BRIEF.md
# Speculative Transaction Read-Set / Write-Set Cache

This block sits beside a processor and runs one speculative transaction block at a time. It keeps two small fully associative arrays. The read-set array gets an entry for every line the transaction loads, and that entry keeps the value the load saw. The write-set array holds the transaction's stores until they commit. Loads that hit the write set return the newest buffered value. Loads that hit only the read set return the value held there, with no memory access. Loads that miss both arrays read backing memory and allocate a read-set entry.

Committed writes from other processors arrive on a snoop port. If one of them hits the read set, the transaction aborts at once. On an abort the write set is discarded and the conflicting read-set entry takes the snooped value, so the re-execution can run from the arrays without refetching. The transaction ends on a store flagged as the last one. The block then requests the commit slot. When the slot is granted and no conflict arrives in that cycle, it broadcasts every buffered write, one per cycle, and pulses a done flag. Ordering between processors is handled by whoever drives the grant.

Top module: `spec_txn_cache`

## Requirements
- R1: After reset the block is idle: stall_o, abort_o, commit_req_o, bc_valid_o, commit_done_o and rsp_valid_o are low, and no request is accepted until txn_start_i is pulsed.
- R2: An accepted load that misses both arrays drives mem_rd_en_o in the same cycle, allocates a read-set entry holding mem_rd_data_i, and returns that data with rsp_valid_o one cycle later.
- R3: A load that hits only the read set returns the held value one cycle later with mem_rd_en_o low.
- R4: A load that hits the write set returns the buffered store data, ahead of the read-set or memory value.
- R5: Several stores to the same line use a single write-set entry, and a later load sees the last stored value.
- R6: A valid snoop whose address is in the read set while a transaction is running or waiting to commit raises abort_o for one cycle on the next cycle. The read-set entry then holds the snooped data.
- R7: A snoop to an address that is not in the read set has no effect: abort_o stays low.
- R8: After an abort the write set is empty. A load to a line that was only stored returns memory data, and a load to a tracked line returns the read-set value without a memory read.
- R9: An accepted store with req_end_i=1 ends the transaction. From the next cycle commit_req_o is high and req_ready_o is low until the grant.
- R10: When commit_grant_i is high while waiting, with no conflict in that cycle, each buffered write appears once on bc_valid_o/bc_addr_o/bc_data_o in ascending slot order, starting in the next cycle and taking one cycle per write. In the cycle after the last write commit_done_o is high, and the block then returns to idle.
- R11: A conflicting snoop in the same cycle as the grant causes an abort instead of a broadcast.
- R12: A request that needs a new entry in a full array raises stall_o, is not accepted, and leaves every entry in place. Requests that hit an existing entry are still accepted.
- R13: txn_start_i empties the read set, so the first load of a line in the new transaction reads memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_start_i | input | 1 | Begins a new transaction while idle |
| req_valid_i | input | 1 | CPU request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_end_i | input | 1 | Store ends the transaction |
| req_addr_i | input | ADDR_W | Line address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Request accepted this cycle |
| stall_o | output | 1 | Request blocked by a full array |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_data_o | output | DATA_W | Load data |
| mem_rd_en_o | output | 1 | Backing memory read |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_data_i | input | DATA_W | Memory read data, same cycle |
| snp_valid_i | input | 1 | Foreign committed write valid |
| snp_addr_i | input | ADDR_W | Foreign write address |
| snp_data_i | input | DATA_W | Foreign write data |
| abort_o | output | 1 | Abort/restart pulse |
| commit_req_o | output | 1 | Requests the commit slot |
| commit_grant_i | input | 1 | Commit slot granted |
| bc_valid_o | output | 1 | Broadcast write valid |
| bc_addr_o | output | ADDR_W | Broadcast address |
| bc_data_o | output | DATA_W | Broadcast data |
| commit_done_o | output | 1 | Broadcast finished |

## Verification
The assertions take it that the CPU alone allocates entries, so an address appears at most once in each array, and that nothing other than txn_start_i or an abort removes entries. The stimulus keeps to this. It raises txn_start_i only while idle, drives commit_grant_i only while commit_req_o is high, and never sends a snoop to an address in the same cycle as a load that allocates that address. Backing memory in the bench is updated only by the block's broadcasts, by snoops, and by explicit writes between transactions, so each expected load value follows from the requirements.

// File: rtl/stc_pkg.sv
package stc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_BCAST = 2'd3
    } txn_state_e;
endpackage

// File: rtl/stc_read_set.sv
module stc_read_set #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o,
    input  logic              alloc_i,
    input  logic [DATA_W-1:0] alloc_data_i,
    output logic              full_o,
    input  logic              snp_en_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic              snp_hit_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][DATA_W-1:0] val;
    } rs_state_t;

    rs_state_t st_d, st_q;
    logic [ENTRIES-1:0] lk_match, snp_match;
    logic [IDX_W-1:0]   free_idx;

    always_comb begin
        st_d      = st_q;
        lk_data_o = '0;
        free_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_match[i]  = st_q.vld[i] && (st_q.tag[i] == lk_addr_i);
            snp_match[i] = snp_en_i && snp_valid_i && st_q.vld[i] &&
                           (st_q.tag[i] == snp_addr_i);
            if (lk_match[i]) lk_data_o = lk_data_o | st_q.val[i];
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) free_idx = IDX_W'(i);
        end
        lk_hit_o  = |lk_match;
        snp_hit_o = |snp_match;
        full_o    = &st_q.vld;

        if (clear_i) begin
            st_d.vld = '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (snp_match[i]) st_d.val[i] = snp_data_i;
            end
            if (alloc_i && !lk_hit_o && !full_o) begin
                st_d.vld[free_idx] = 1'b1;
                st_d.tag[free_idx] = lk_addr_i;
                st_d.val[free_idx] = alloc_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a line is tracked by at most one read-set entry
    p_rs_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R12: a full read set stays full until it is cleared
    p_rs_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clear_i) |=> full_o);
endmodule

// File: rtl/stc_write_set.sv
module stc_write_set #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o,
    input  logic              write_i,
    input  logic [DATA_W-1:0] write_data_i,
    output logic              full_o,
    output logic              any_o,
    input  logic              pop_i,
    output logic              head_valid_o,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [DATA_W-1:0] head_data_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][DATA_W-1:0] val;
    } ws_state_t;

    ws_state_t st_d, st_q;
    logic [ENTRIES-1:0] lk_match;
    logic [IDX_W-1:0]   free_idx, hit_idx, head_idx;

    always_comb begin
        st_d      = st_q;
        lk_data_o = '0;
        free_idx  = '0;
        hit_idx   = '0;
        head_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_match[i] = st_q.vld[i] && (st_q.tag[i] == lk_addr_i);
            if (lk_match[i]) begin
                lk_data_o = lk_data_o | st_q.val[i];
                hit_idx   = hit_idx | IDX_W'(i);
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) free_idx = IDX_W'(i);
            if (st_q.vld[i])  head_idx = IDX_W'(i);
        end
        lk_hit_o     = |lk_match;
        full_o       = &st_q.vld;
        any_o        = |st_q.vld;
        head_valid_o = any_o;
        head_addr_o  = st_q.tag[head_idx];
        head_data_o  = st_q.val[head_idx];

        if (clear_i) begin
            st_d.vld = '0;
        end else if (pop_i && any_o) begin
            st_d.vld[head_idx] = 1'b0;
        end else if (write_i) begin
            if (lk_hit_o) begin
                st_d.val[hit_idx] = write_data_i;
            end else if (!full_o) begin
                st_d.vld[free_idx] = 1'b1;
                st_d.tag[free_idx] = lk_addr_i;
                st_d.val[free_idx] = write_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: stores to one line coalesce into a single entry
    p_ws_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R10: a pop always removes a real entry
    p_ws_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> any_o);
endmodule

// File: rtl/spec_txn_cache.sv
module spec_txn_cache #(
    parameter int RS_ENTRIES = 4,
    parameter int WS_ENTRIES = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_end_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              stall_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic              abort_o,
    output logic              commit_req_o,
    input  logic              commit_grant_i,
    output logic              bc_valid_o,
    output logic [ADDR_W-1:0] bc_addr_o,
    output logic [DATA_W-1:0] bc_data_o,
    output logic              commit_done_o
);
    import stc_pkg::*;

    typedef struct packed {
        txn_state_e        state;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              abort;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic              rs_hit, rs_full, rs_snp_hit, rs_clear, rs_alloc;
    logic [DATA_W-1:0] rs_data;
    logic              ws_hit, ws_full, ws_any, ws_head_vld, ws_write, ws_pop;
    logic [DATA_W-1:0] ws_data, ws_head_data;
    logic [ADDR_W-1:0] ws_head_addr;
    logic              active, conflict, is_load, is_store;
    logic              need_rs, need_ws, blocked, accept;

    stc_read_set #(.ENTRIES(RS_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rs_i (
        .clk(clk), .rst_n(rst_n), .clear_i(rs_clear),
        .lk_addr_i(req_addr_i), .lk_hit_o(rs_hit), .lk_data_o(rs_data),
        .alloc_i(rs_alloc), .alloc_data_i(mem_rd_data_i), .full_o(rs_full),
        .snp_en_i(active), .snp_valid_i(snp_valid_i), .snp_addr_i(snp_addr_i),
        .snp_data_i(snp_data_i), .snp_hit_o(rs_snp_hit)
    );

    stc_write_set #(.ENTRIES(WS_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) ws_i (
        .clk(clk), .rst_n(rst_n), .clear_i(conflict),
        .lk_addr_i(req_addr_i), .lk_hit_o(ws_hit), .lk_data_o(ws_data),
        .write_i(ws_write), .write_data_i(req_wdata_i), .full_o(ws_full),
        .any_o(ws_any), .pop_i(ws_pop), .head_valid_o(ws_head_vld),
        .head_addr_o(ws_head_addr), .head_data_o(ws_head_data)
    );

    always_comb begin
        c_d      = c_q;
        active   = (c_q.state == ST_RUN) || (c_q.state == ST_WAIT);
        conflict = rs_snp_hit;
        is_load  = req_valid_i && !req_write_i;
        is_store = req_valid_i && req_write_i;
        need_rs  = is_load && !ws_hit && !rs_hit;
        need_ws  = is_store && !ws_hit;
        blocked  = (need_rs && rs_full) || (need_ws && ws_full);

        stall_o     = (c_q.state == ST_RUN) && !conflict && blocked;
        req_ready_o = (c_q.state == ST_RUN) && !conflict && !blocked;
        accept      = req_valid_i && req_ready_o;

        mem_rd_en_o   = accept && need_rs;
        mem_rd_addr_o = req_addr_i;
        rs_alloc      = mem_rd_en_o;
        rs_clear      = (c_q.state == ST_IDLE) && txn_start_i;
        ws_write      = accept && req_write_i;

        bc_valid_o    = (c_q.state == ST_BCAST) && ws_head_vld;
        bc_addr_o     = ws_head_addr;
        bc_data_o     = ws_head_data;
        ws_pop        = bc_valid_o;
        commit_done_o = (c_q.state == ST_BCAST) && !ws_head_vld;
        commit_req_o  = (c_q.state == ST_WAIT);

        c_d.rsp_valid = accept && !req_write_i;
        c_d.rsp_data  = ws_hit ? ws_data : (rs_hit ? rs_data : mem_rd_data_i);
        c_d.abort     = conflict;

        unique case (c_q.state)
            ST_IDLE:  if (txn_start_i) c_d.state = ST_RUN;
            ST_RUN:   if (!conflict && accept && req_write_i && req_end_i)
                          c_d.state = ST_WAIT;
            ST_WAIT:  if (conflict)            c_d.state = ST_RUN;
                      else if (commit_grant_i) c_d.state = ST_BCAST;
            ST_BCAST: if (!ws_head_vld)        c_d.state = ST_IDLE;
            default:  c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state     <= ST_IDLE;
            c_q.rsp_valid <= 1'b0;
            c_q.rsp_data  <= '0;
            c_q.abort     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid_o = c_q.rsp_valid;
    assign rsp_data_o  = c_q.rsp_data;
    assign abort_o     = c_q.abort;

    // R12: a stalled request is never accepted
    p_stall_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !req_ready_o);

    // R8: the abort pulse coincides with an empty write set
    p_abort_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !ws_any);

    // R9: no request is taken while the commit slot is requested
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req_o |-> !req_ready_o);

    // R10: a broadcast runs without gaps until done
    p_bc_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid_o |=> (bc_valid_o || commit_done_o));

    // R6: abort only follows a running or waiting transaction
    p_abort_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (c_q.state == ST_RUN));
endmodule

// File: tb/spec_txn_cache_tb_top.sv
`timescale 1ns/1ps
module spec_txn_cache_tb_top;
    localparam logic [2:0] OP_START = 3'd0;
    localparam logic [2:0] OP_LOAD  = 3'd1;
    localparam logic [2:0] OP_STORE = 3'd2;
    localparam logic [2:0] OP_END   = 3'd3;
    localparam logic [2:0] OP_SNOOP = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic        mrd;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{OP_START, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd13},
        '{OP_LOAD,  8'h10, 16'h0000, 16'h0094, 1'b1, 4'd2},  // R2
        '{OP_LOAD,  8'h11, 16'h0000, 16'h0097, 1'b1, 4'd2},  // R2
        '{OP_LOAD,  8'h10, 16'h0000, 16'h0094, 1'b0, 4'd3},  // R3
        '{OP_STORE, 8'h10, 16'hAAAA, 16'h0000, 1'b0, 4'd4},
        '{OP_LOAD,  8'h10, 16'h0000, 16'hAAAA, 1'b0, 4'd4},  // R4
        '{OP_STORE, 8'h10, 16'hBBBB, 16'h0000, 1'b0, 4'd5},
        '{OP_LOAD,  8'h10, 16'h0000, 16'hBBBB, 1'b0, 4'd5},  // R5
        '{OP_SNOOP, 8'h30, 16'h0303, 16'h0000, 1'b0, 4'd7},  // R7
        '{OP_SNOOP, 8'h11, 16'h5555, 16'h0001, 1'b0, 4'd6},  // R6
        '{OP_LOAD,  8'h10, 16'h0000, 16'h0094, 1'b0, 4'd8},  // R8
        '{OP_LOAD,  8'h11, 16'h0000, 16'h5555, 1'b0, 4'd6},  // R6
        '{OP_STORE, 8'h12, 16'h1234, 16'h0000, 1'b0, 4'd10},
        '{OP_END,   8'h20, 16'h0777, 16'h0000, 1'b0, 4'd9}   // R9
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        txn_start, req_valid, req_write, req_end, snp_valid, grant;
    logic [7:0]  req_addr, snp_addr;
    logic [15:0] req_wdata, snp_data;
    logic        req_ready, stall, rsp_valid, mem_rd_en, abort_w;
    logic        commit_req, bc_valid, commit_done;
    logic [15:0] rsp_data, mem_rd_data, bc_data;
    logic [7:0]  mem_rd_addr, bc_addr;
    logic [15:0] mem [256];
    int          checks = 0, fails = 0;
    logic        mrd_seen, rdy_seen;

    always #4 clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr];

    spec_txn_cache dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_end_i(req_end),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .stall_o(stall), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr),
        .mem_rd_data_i(mem_rd_data), .snp_valid_i(snp_valid),
        .snp_addr_i(snp_addr), .snp_data_i(snp_data), .abort_o(abort_w),
        .commit_req_o(commit_req), .commit_grant_i(grant),
        .bc_valid_o(bc_valid), .bc_addr_o(bc_addr), .bc_data_o(bc_data),
        .commit_done_o(commit_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic idle_inputs();
        txn_start = 0; req_valid = 0; req_write = 0; req_end = 0;
        req_addr = '0; req_wdata = '0; snp_valid = 0; snp_addr = '0;
        snp_data = '0; grant = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input string req);
        case (v.op)
            OP_START: txn_start = 1;
            OP_LOAD:  begin req_valid = 1; req_addr = v.addr; end
            OP_STORE, OP_END: begin
                req_valid = 1; req_write = 1; req_end = (v.op == OP_END);
                req_addr = v.addr; req_wdata = v.data;
            end
            OP_SNOOP: begin
                snp_valid = 1; snp_addr = v.addr; snp_data = v.data;
                mem[v.addr] = v.data;
            end
            default: ;
        endcase
        #1;
        mrd_seen = mem_rd_en;
        rdy_seen = req_ready;
        tick();
        idle_inputs();
        case (v.op)
            OP_LOAD: begin
                chk(rsp_valid && rsp_data == v.exp, req, {15'd0, rsp_valid, rsp_data},
                    {16'd1, v.exp});
                chk(mrd_seen == v.mrd, req, 32'(mrd_seen), 32'(v.mrd));
            end
            OP_STORE: chk(rdy_seen == 1'b1, req, 32'(rdy_seen), 32'd1);
            OP_END: begin
                chk(rdy_seen == 1'b1, req, 32'(rdy_seen), 32'd1);
                chk(commit_req == 1'b1, req, 32'(commit_req), 32'd1);
            end
            OP_SNOOP: chk(abort_w == v.exp[0], req, 32'(abort_w), 32'(v.exp[0]));
            default: ;
        endcase
    endtask

    function automatic vec_t mk(input logic [2:0] op, input logic [7:0] a,
                                input logic [15:0] d, input logic [15:0] e,
                                input logic m);
        mk = '{op, a, d, e, m, 4'd0};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_tb();
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 16'(100 + 3 * a);
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state and no acceptance before a transaction starts
        chk({stall, abort_w, commit_req, bc_valid, commit_done, rsp_valid} == 6'b0,
            "R1 idle outputs", 32'({stall, abort_w, commit_req, bc_valid, commit_done,
            rsp_valid}), 32'd0);
        req_valid = 1; req_addr = 8'h10;
        #1;
        chk(req_ready == 1'b0, "R1 not started", 32'(req_ready), 32'd0);
        tick();
        idle_inputs();
        chk(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("R%0d vec%0d", VECS[i].tag, i));

        // R9: waiting for commit, requests are refused
        req_valid = 1; req_addr = 8'h10;
        #1;
        chk(req_ready == 1'b0, "R9 ready while waiting", 32'(req_ready), 32'd0);
        tick();
        idle_inputs();
        chk(commit_req == 1'b1 && rsp_valid == 1'b0, "R9 hold",
            {commit_req, rsp_valid}, 32'b10);

        // R10: grant and ordered broadcast
        grant = 1;
        tick();
        idle_inputs();
        chk(bc_valid && bc_addr == 8'h12 && bc_data == 16'h1234, "R10 bc0",
            {7'd0, bc_valid, bc_addr, bc_data}, {7'd0, 1'b1, 8'h12, 16'h1234});
        mem[bc_addr] = bc_data;
        tick();
        chk(bc_valid && bc_addr == 8'h20 && bc_data == 16'h0777, "R10 bc1",
            {7'd0, bc_valid, bc_addr, bc_data}, {7'd0, 1'b1, 8'h20, 16'h0777});
        mem[bc_addr] = bc_data;
        tick();
        chk(commit_done && !bc_valid, "R10 done", {commit_done, bc_valid}, 32'b10);
        tick();
        chk(!commit_done && !commit_req, "R10 idle", {commit_done, commit_req}, 32'b0);

        // R13: a new transaction forgets the previous read set
        mem[8'h10] = 16'h0999;
        run_vec(mk(OP_START, 8'h00, 16'h0, 16'h0, 1'b0), "R13 start");
        run_vec(mk(OP_LOAD, 8'h10, 16'h0, 16'h0999, 1'b1), "R13 refetch");

        // R11: conflict in the grant cycle aborts instead of broadcasting
        run_vec(mk(OP_LOAD, 8'h12, 16'h0, 16'h1234, 1'b1), "R11 setup load");
        run_vec(mk(OP_END, 8'h40, 16'h4444, 16'h0, 1'b0), "R11 end store");
        grant = 1; snp_valid = 1; snp_addr = 8'h12; snp_data = 16'h2222;
        mem[8'h12] = 16'h2222;
        tick();
        idle_inputs();
        chk(abort_w && !bc_valid && !commit_req, "R11 abort on grant",
            {abort_w, bc_valid, commit_req}, 32'b100);
        run_vec(mk(OP_LOAD, 8'h40, 16'h0, 16'h0124, 1'b1), "R11 store dropped");
        run_vec(mk(OP_LOAD, 8'h12, 16'h0, 16'h2222, 1'b0), "R11 refreshed value");

        // R12: full read set stalls new lines and keeps tracking
        run_vec(mk(OP_LOAD, 8'h50, 16'h0, 16'h0154, 1'b1), "R12 fill");
        req_valid = 1; req_addr = 8'h51;
        #1;
        chk(stall && !req_ready, "R12 read-set stall", {stall, req_ready}, 32'b10);
        tick();
        idle_inputs();
        chk(rsp_valid == 1'b0, "R12 stalled load ignored", 32'(rsp_valid), 32'd0);
        run_vec(mk(OP_LOAD, 8'h10, 16'h0, 16'h0999, 1'b0), "R12 hit while full");
        run_vec(mk(OP_SNOOP, 8'h50, 16'h0505, 16'h0001, 1'b0), "R12 still tracked");

        // R12: full write set
        for (int k = 0; k < 4; k++)
            run_vec(mk(OP_STORE, 8'(8'h60 + k), 16'(16'hC000 + k), 16'h0, 1'b0),
                    "R12 ws fill");
        req_valid = 1; req_write = 1; req_addr = 8'h64; req_wdata = 16'hDEAD;
        #1;
        chk(stall && !req_ready, "R12 write-set stall", {stall, req_ready}, 32'b10);
        tick();
        idle_inputs();
        run_vec(mk(OP_STORE, 8'h60, 16'hCAFE, 16'h0, 1'b0), "R12 ws hit while full");
        run_vec(mk(OP_LOAD, 8'h60, 16'h0, 16'hCAFE, 1'b0), "R12 ws value");
        run_vec(mk(OP_LOAD, 8'h63, 16'h0, 16'hC003, 1'b0), "R12 ws kept");

        finish_tb();
    end
endmodule